// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits between the interrupt request lines of a small microcontroller and its CPU core. It looks at a reset request, a software trap request and fourteen numbered maskable request lines. From these it picks the one source with the highest priority that is currently allowed to run. Each maskable source owns a 16-bit vector address, spaced two bytes apart and counting down from the top of memory. Slots 6 and 13 are reserved and never win.

The selection is combinational. It is shown at once on `pend_any`. When the CPU pulses `take`, the winner's vector, index and a valid flag are captured into output registers. They stay there until the next `take`.

A separate wake path watches the same request lines while the core is in a low-power state. It raises `wake` for any source that a per-source table allows to end halt. The global mask bit has no effect on this path. The wake-up timer source can end only the auto-wake halt state.

Top module: `irq_vector_arbiter`

## Requirements
- R1: An asserted `rst_req` always wins. A `take` then captures index 15 and vector FFFEh, whatever the mask bit and the other requests are.
- R2: With `rst_req` low and `trap_req` high, a `take` captures index 14 and vector FFFCh, even when `i_mask` is 1.
- R3: A maskable source n (0..13) that wins is captured with index n and vector FFFAh − 2·n. So source 0 gives FFFAh, source 5 gives FFF0h and source 12 gives FFE2h.
- R4: When several maskable sources are eligible, the one with the lowest index wins.
- R5: While `i_mask` is 1, maskable requests are ignored. If no reset or trap is pending, `pend_any` is 0 and a `take` captures valid 0, index 0 and vector 0000h.
- R6: Request lines 6 and 13 never win arbitration. Driving them alone leaves `pend_any` at 0.
- R7: `vec_q`, `idx_q` and `vld_q` change only on a clock edge where `take` is 1. On other edges they hold their values, even when the inputs change.
- R8: When `lp_mode` is 01 (halt) or 10 (auto-wake halt), `wake` is 1 in the same cycle as `rst_req` or a request on a halt-exit-enabled source (1, 2, 3, 4, 11, 12), whatever `i_mask` is. Requests on sources 5 to 10 and 13 do not raise `wake`.
- R9: Source 0 (wake-up timer) raises `wake` when `lp_mode` is 10, and does not raise it when `lp_mode` is 01.
- R10: When `lp_mode` is 00 (run) or 11, `wake` is 0.
- R11: After reset, `vld_q` is 0, `idx_q` is 0 and `vec_q` is 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| rst_req | input | 1 | Reset request, highest priority, cannot be masked |
| trap_req | input | 1 | Software trap request, cannot be masked |
| irq_req | input | 14 | Level-held maskable requests, bit n is source n |
| i_mask | input | 1 | Global mask bit: 1 blocks maskable sources |
| lp_mode | input | 2 | 00 run, 01 halt, 10 auto-wake halt, 11 treated as run |
| take | input | 1 | CPU strobe: capture the current selection |
| pend_any | output | 1 | Some source is currently selected |
| vld_q | output | 1 | Captured selection was valid |
| idx_q | output | 4 | Captured index: 0..13 maskable, 14 trap, 15 reset |
| vec_q | output | 16 | Captured vector address |
| wake | output | 1 | Request to leave the low-power state |

## Verification
A fault in the priority encoder or the masking stage shows up as a wrong index or vector in the registers one clock edge after the `take` that captures it. For this reason every capture is checked against an independent model of the priority order. A wrong halt-exit table or a wrong mode decode shows on `wake` in the same cycle as the stimulus, so those checks sample it combinationally. A capture register that loads on the wrong edge shows up when the inputs change with `take` low and the registers are expected to stay the same.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   // Low-power state reported by the core
   typedef enum logic [1:0] {
      LP_RUN      = 2'b00,
      LP_HALT     = 2'b01,
      LP_AWU_HALT = 2'b10,
      LP_RSVD     = 2'b11
   } lp_mode_e;

   // Encoder implementation variant
   typedef enum int {
      ENC_LINEAR = 0,
      ENC_ONEHOT = 1
   } enc_style_e;

endpackage

// File: rtl/irqv_mask_stage.sv
module irqv_mask_stage #(
   parameter int          NUM_SRC     = 14,
   parameter logic [13:0] UNUSED_MASK = 14'h2040
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic               i_mask,
   output logic [NUM_SRC-1:0] elig
);

   // One qualification gate per source; reserved slots are tied off
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
      if (UNUSED_MASK[n]) begin : g_tie
         assign elig[n] = 1'b0;
      end else begin : g_live
         assign elig[n] = req[n] & ~i_mask;
      end
   end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
   parameter int NUM_SRC   = 14,
   parameter int ENC_STYLE = 0,
   localparam int SIDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] elig,
   output logic               hit,
   output logic [SIDX_W-1:0]  idx
);

   assign hit = |elig;

   if (ENC_STYLE == irqv_pkg::ENC_ONEHOT) begin : g_onehot
      // Isolate lowest set bit, then OR-encode
      logic [NUM_SRC-1:0] low1;
      assign low1 = elig & (~elig + NUM_SRC'(1));
      always_comb begin
         idx = '0;
         for (int n = 0; n < NUM_SRC; n++) begin
            if (low1[n]) idx = idx | SIDX_W'(n);
         end
      end
   end else begin : g_linear
      // Scan from lowest priority upward so the lowest index lands last
      always_comb begin
         idx = '0;
         for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (elig[n]) idx = SIDX_W'(n);
         end
      end
   end

endmodule

// File: rtl/irqv_wake_ctl.sv
module irqv_wake_ctl #(
   parameter int          NUM_SRC        = 14,
   parameter logic [13:0] UNUSED_MASK    = 14'h2040,
   parameter logic [13:0] HALT_EXIT_MASK = 14'h181F,
   parameter int          AWU_SRC        = 0
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic               rst_req,
   input  logic [1:0]         lp_mode,
   output logic               wake
);
   import irqv_pkg::*;

   localparam logic [NUM_SRC-1:0] AWU_BIT  = NUM_SRC'(1) << AWU_SRC;
   localparam logic [NUM_SRC-1:0] LIVE     = HALT_EXIT_MASK[NUM_SRC-1:0] & ~UNUSED_MASK[NUM_SRC-1:0];
   localparam logic [NUM_SRC-1:0] HALT_OK  = LIVE & ~AWU_BIT;
   localparam logic [NUM_SRC-1:0] AWUH_OK  = LIVE;

   lp_mode_e mode;
   logic     halt_hit, awuh_hit;

   assign mode     = lp_mode_e'(lp_mode);
   assign halt_hit = |(req & HALT_OK);
   assign awuh_hit = |(req & AWUH_OK);

   always_comb begin
      unique case (mode)
         LP_HALT:     wake = rst_req | halt_hit;
         LP_AWU_HALT: wake = rst_req | awuh_hit;
         default:     wake = 1'b0;
      endcase
   end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
   parameter int          NUM_SRC        = 14,
   parameter int          VEC_W          = 16,
   parameter logic [15:0] VEC_RESET      = 16'hFFFE,
   parameter logic [15:0] VEC_TRAP       = 16'hFFFC,
   parameter logic [15:0] VEC_BASE       = 16'hFFFA,
   parameter int          VEC_STRIDE     = 2,
   parameter logic [13:0] UNUSED_MASK    = 14'h2040,
   parameter logic [13:0] HALT_EXIT_MASK = 14'h181F,
   parameter int          AWU_SRC        = 0,
   parameter int          ENC_STYLE      = 0,
   localparam int         IDX_W          = $clog2(NUM_SRC + 2),
   localparam int         SIDX_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req,
   input  logic               trap_req,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               i_mask,
   input  logic [1:0]         lp_mode,
   input  logic               take,
   output logic               pend_any,
   output logic               vld_q,
   output logic [IDX_W-1:0]   idx_q,
   output logic [VEC_W-1:0]   vec_q,
   output logic               wake
);

   localparam logic [IDX_W-1:0] IDX_TRAP  = IDX_W'(NUM_SRC);
   localparam logic [IDX_W-1:0] IDX_RESET = IDX_W'(NUM_SRC + 1);

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > 14) begin : g_bad_num
      $error("NUM_SRC must be within 1..14");
   end
   if (VEC_W < 2 || VEC_W > 16) begin : g_bad_vw
      $error("VEC_W must be within 2..16");
   end
   if (AWU_SRC < 0 || AWU_SRC >= NUM_SRC) begin : g_bad_awu
      $error("AWU_SRC out of range");
   end
   if (ENC_STYLE != 0 && ENC_STYLE != 1) begin : g_bad_enc
      $error("ENC_STYLE must be 0 or 1");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("VEC_STRIDE must be positive");
   end

   logic [NUM_SRC-1:0] elig;
   logic               m_hit;
   logic [SIDX_W-1:0]  m_idx;
   logic [VEC_W-1:0]   m_vec;
   logic               sel_vld;
   logic [IDX_W-1:0]   sel_idx;
   logic [VEC_W-1:0]   sel_vec;

   irqv_mask_stage #(
      .NUM_SRC     (NUM_SRC),
      .UNUSED_MASK (UNUSED_MASK)
   ) u_mask (
      .req    (irq_req),
      .i_mask (i_mask),
      .elig   (elig)
   );

   irqv_prio_enc #(
      .NUM_SRC   (NUM_SRC),
      .ENC_STYLE (ENC_STYLE)
   ) u_enc (
      .elig (elig),
      .hit  (m_hit),
      .idx  (m_idx)
   );

   irqv_wake_ctl #(
      .NUM_SRC        (NUM_SRC),
      .UNUSED_MASK    (UNUSED_MASK),
      .HALT_EXIT_MASK (HALT_EXIT_MASK),
      .AWU_SRC        (AWU_SRC)
   ) u_wake (
      .req     (irq_req),
      .rst_req (rst_req),
      .lp_mode (lp_mode),
      .wake    (wake)
   );

   // Vector by fixed downward stride
   assign m_vec = VEC_BASE[VEC_W-1:0] - (VEC_W'(VEC_STRIDE) * VEC_W'(m_idx));

   // Reset over trap over maskable
   always_comb begin
      sel_vld = 1'b1;
      if (rst_req) begin
         sel_idx = IDX_RESET;
         sel_vec = VEC_RESET[VEC_W-1:0];
      end else if (trap_req) begin
         sel_idx = IDX_TRAP;
         sel_vec = VEC_TRAP[VEC_W-1:0];
      end else if (m_hit) begin
         sel_idx = IDX_W'(m_idx);
         sel_vec = m_vec;
      end else begin
         sel_vld = 1'b0;
         sel_idx = '0;
         sel_vec = '0;
      end
   end

   assign pend_any = sel_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         idx_q <= '0;
         vec_q <= '0;
      end else if (take) begin
         vld_q <= sel_vld;
         idx_q <= sel_idx;
         vec_q <= sel_vec;
      end
   end

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
   parameter int          NUM_SRC     = 14,
   parameter int          VEC_W       = 16,
   parameter logic [15:0] VEC_BASE    = 16'hFFFA,
   parameter int          VEC_STRIDE  = 2,
   parameter logic [13:0] UNUSED_MASK = 14'h2040,
   localparam int         IDX_W       = $clog2(NUM_SRC + 2)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rst_req,
   input logic               trap_req,
   input logic               i_mask,
   input logic [1:0]         lp_mode,
   input logic               take,
   input logic               pend_any,
   input logic               vld_q,
   input logic [IDX_W-1:0]   idx_q,
   input logic [VEC_W-1:0]   vec_q,
   input logic               wake
);

   assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rst_req) |=> (vld_q && idx_q == IDX_W'(NUM_SRC + 1)));

   assert_trap_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !rst_req && trap_req) |=> (vld_q && idx_q == IDX_W'(NUM_SRC)));

   assert_vector_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && idx_q < IDX_W'(NUM_SRC)) |->
         (vec_q == VEC_BASE[VEC_W-1:0] - VEC_W'(VEC_STRIDE) * VEC_W'(idx_q)));

   assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && i_mask && !rst_req && !trap_req) |=> !vld_q);

   assert_unused_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && idx_q < IDX_W'(NUM_SRC)) |-> !UNUSED_MASK[idx_q]);

   assert_hold_without_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(vld_q) && $stable(idx_q) && $stable(vec_q)));

   assert_reset_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && (lp_mode == 2'b01 || lp_mode == 2'b10)) |-> wake);

   assert_run_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'b00 || lp_mode == 2'b11) |-> !wake);

endmodule

bind irq_vector_arbiter irqv_chk #(
   .NUM_SRC     (NUM_SRC),
   .VEC_W       (VEC_W),
   .VEC_BASE    (VEC_BASE),
   .VEC_STRIDE  (VEC_STRIDE),
   .UNUSED_MASK (UNUSED_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rst_req  (rst_req),
   .trap_req (trap_req),
   .i_mask   (i_mask),
   .lp_mode  (lp_mode),
   .take     (take),
   .pend_any (pend_any),
   .vld_q    (vld_q),
   .idx_q    (idx_q),
   .vec_q    (vec_q),
   .wake     (wake)
);

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0;
   logic        trap_req = 1'b0;
   logic [13:0] irq_req = '0;
   logic        i_mask = 1'b0;
   logic [1:0]  lp_mode = 2'b00;
   logic        take = 1'b0;
   logic        pend_any, vld_q, wake;
   logic [3:0]  idx_q;
   logic [15:0] vec_q;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   bit take_seen = 0;

   // {requirement tag, vld, idx, vec}
   typedef struct {
      string       tag;
      logic [20:0] exp;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;   // 125 MHz

   irq_vector_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .trap_req(trap_req),
      .irq_req(irq_req), .i_mask(i_mask), .lp_mode(lp_mode), .take(take),
      .pend_any(pend_any), .vld_q(vld_q), .idx_q(idx_q), .vec_q(vec_q),
      .wake(wake)
   );

   // Model from the requirements: reset 15/FFFE, trap 14/FFFC,
   // source n -> n/FFFA-2n, lowest n wins, slots 6 and 13 dead.
   function automatic logic [20:0] model(logic r, logic t, logic [13:0] q, logic m);
      if (r) return {1'b1, 4'd15, 16'hFFFE};
      if (t) return {1'b1, 4'd14, 16'hFFFC};
      if (!m) begin
         for (int n = 0; n < 14; n++) begin
            if (q[n] && n != 6 && n != 13)
               return {1'b1, 4'(n), 16'hFFFA - 16'(2 * n)};
         end
      end
      return 21'd0;
   endfunction

   task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: apply inputs with take, push the expected capture
   task automatic drive(string tag, logic r, logic t, logic [13:0] q, logic m);
      item_t it;
      @(negedge clk);
      rst_req = r; trap_req = t; irq_req = q; i_mask = m; take = 1'b1;
      #1;
      check({tag, " pend_any"}, {20'd0, pend_any}, {20'd0, model(r, t, q, m)[20]});
      it.tag = tag;
      it.exp = model(r, t, q, m);
      sb_q.push_back(it);
      @(negedge clk);
      take = 1'b0;
   endtask

   // Monitor: after an edge that saw take, compare the captured registers
   always @(posedge clk) take_seen <= take;

   always @(negedge clk) begin
      if (take_seen) begin
         if (sb_q.size() == 0) begin
            check("R7 unexpected capture", 21'd1, 21'd0);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, {vld_q, idx_q, vec_q}, it.exp);
         end
      end
   end

   task automatic wake_chk(string tag, logic [1:0] md, logic r, logic [13:0] q, logic m, logic exp);
      @(negedge clk);
      lp_mode = md; rst_req = r; irq_req = q; i_mask = m; trap_req = 1'b0;
      #1;
      check(tag, {20'd0, wake}, {20'd0, exp});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 reset state", {vld_q, idx_q, vec_q}, 21'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after release", {vld_q, idx_q, vec_q}, 21'd0);

      drive("R1 reset wins", 1'b1, 1'b1, 14'h3FFF, 1'b1);
      drive("R2 trap through mask", 1'b0, 1'b1, 14'h0002, 1'b1);
      drive("R4 lowest of 3 and 9", 1'b0, 1'b0, 14'h0208, 1'b0);
      drive("R3 source 0", 1'b0, 1'b0, 14'h0001, 1'b0);
      drive("R3 source 12", 1'b0, 1'b0, 14'h1000, 1'b0);
      drive("R5 masked", 1'b0, 1'b0, 14'h0FFF, 1'b1);
      drive("R6 only unused", 1'b0, 1'b0, 14'h2040, 1'b0);
      drive("R6 unused skipped", 1'b0, 1'b0, 14'h20C0, 1'b0);
      drive("R4 all pending", 1'b0, 1'b0, 14'h3FFE, 1'b0);
      for (int n = 0; n < 14; n++) begin
         drive($sformatf("R3 sweep source %0d", n), 1'b0, 1'b0, 14'(1 << n), 1'b0);
      end

      // Capture a known value, then change inputs without take
      drive("R7 setup", 1'b0, 1'b0, 14'h0010, 1'b0);
      @(negedge clk);
      rst_req = 1'b1; trap_req = 1'b1; irq_req = 14'h0001;
      repeat (3) @(negedge clk);
      check("R7 hold without take", {vld_q, idx_q, vec_q}, {1'b1, 4'd4, 16'hFFF2});
      rst_req = 1'b0; trap_req = 1'b0; irq_req = '0;

      wake_chk("R8 ext1 halt masked",   2'b01, 1'b0, 14'h0002, 1'b1, 1'b1);
      wake_chk("R8 rtc1 halt",          2'b01, 1'b0, 14'h0800, 1'b0, 1'b1);
      wake_chk("R8 spi awu-halt",       2'b10, 1'b0, 14'h1000, 1'b1, 1'b1);
      wake_chk("R8 rtc2 no wake",       2'b01, 1'b0, 14'h0020, 1'b0, 1'b0);
      wake_chk("R8 timers no wake",     2'b10, 1'b0, 14'h07E0, 1'b0, 1'b0);
      wake_chk("R8 unused 13 no wake",  2'b01, 1'b0, 14'h2000, 1'b0, 1'b0);
      wake_chk("R8 reset in halt",      2'b01, 1'b1, 14'h0000, 1'b1, 1'b1);
      wake_chk("R9 awu in plain halt",  2'b01, 1'b0, 14'h0001, 1'b0, 1'b0);
      wake_chk("R9 awu in awu-halt",    2'b10, 1'b0, 14'h0001, 1'b1, 1'b1);
      wake_chk("R10 run mode",          2'b00, 1'b1, 14'h1FFF, 1'b0, 1'b0);
      wake_chk("R10 mode 11",           2'b11, 1'b0, 14'h001F, 1'b0, 1'b0);
      @(negedge clk);
      rst_req = 1'b0; irq_req = '0; lp_mode = 2'b00;

      repeat (4) @(negedge clk);
      if (sb_q.size() != 0) check("R7 queue drained", 21'(sb_q.size()), 21'd0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule